// File: doc/BRIEF.md
# Byte-Lane Aliased Register File

This block holds eight 16-bit registers for a compact integer datapath. There are four data registers and four pointer/index registers. A data register can be used as a full word. It can also be used as two independent 8-bit registers, one for the low byte and one for the high byte. Pointer/index registers are reached only as whole words.

The block has one write port and two read ports, A and B. Each port carries a 2-bit access mode and a 3-bit selector:

- Mode 0 (word) selects any of the eight registers by number.
- Mode 1 (byte code) takes a packed 3-bit byte-register number.
- Mode 2 (explicit low) names a register number and its low byte.
- Mode 3 (explicit high) names a register number and its high byte.

Data registers are numbered 0 to 3. Pointer/index registers are numbered 4 to 7 (stack, base, source and destination). Reads are combinational from the port inputs. A read of a register that is being written in the same cycle sees the value the write leaves behind. The register array updates on the rising clock edge. There is no state sequencer: every access completes in the cycle it is presented.

Top module: `byte_alias_regfile`

## Requirements
- R1: After reset is released, every register reads as 0x0000 in word mode.
- R2: Word mode selects register 0 to 7 by the selector. A read returns all 16 bits. A write replaces all 16 bits with wr_data.
- R3: In byte-code mode, codes 0 to 3 address bits 7:0 of data registers 0 to 3. Codes 4 to 7 address bits 15:8 of data registers 0 to 3. A byte read returns the byte in bits 7:0 with bits 15:8 equal to zero.
- R4: Explicit-low mode with selector 0 to 3 addresses bits 7:0 of that data register. Explicit-high mode with selector 0 to 3 addresses bits 15:8 of it.
- R5: A byte write stores wr_data[7:0] into the addressed byte only. The other byte of the register keeps its value, and wr_data[15:8] has no effect.
- R6: Explicit-low or explicit-high mode with selector 4 to 7 is illegal. On a read it raises that port's illegal flag and returns 0x0000. On an enabled write it raises wr_illegal and leaves every register unchanged.
- R7: When a read port addresses a register written in the same cycle, it returns the post-write value with byte merging applied. This holds on both read ports.
- R8: With wr_en low, no register changes and wr_illegal stays low.
- R9: The two read ports are independent: each returns the data for its own mode and selector in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 2 | Write access mode (0 word, 1 byte code, 2 explicit low, 3 explicit high) |
| wr_sel | input | 3 | Write register or byte-code selector |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| wr_illegal | output | 1 | Enabled write has an illegal mode/selector pair |
| rd_a_mode | input | 2 | Port A access mode |
| rd_a_sel | input | 3 | Port A selector |
| rd_a_data | output | 16 | Port A read data, bytes zero-extended |
| rd_a_illegal | output | 1 | Port A request is illegal |
| rd_b_mode | input | 2 | Port B access mode |
| rd_b_sel | input | 3 | Port B selector |
| rd_b_data | output | 16 | Port B read data, bytes zero-extended |
| rd_b_illegal | output | 1 | Port B request is illegal |

## Verification
The hardest case to reach from the ports is a same-cycle byte write and read of one register, where the read must show the merged word. An example is a high-byte write read back as a full word, or a low-byte write read back through the other byte's code.

The stimulus sweeps every mode and selector on the write port. It aims port A at the whole target word and port B at the written lane in that same cycle. This exposes both the merge and the untouched lane before the clock edge commits the write.

Illegal pointer-byte writes are followed in the same cycle by a word read of the pointer. This shows at the ports that the pointer register was left unchanged.

// File: rtl/rf_alias_pkg.sv
package rf_alias_pkg;

    typedef enum logic [1:0] {
        ACC_WORD  = 2'd0,
        ACC_BCODE = 2'd1,
        ACC_LO    = 2'd2,
        ACC_HI    = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        LANE_WORD = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2
    } lane_e;

endpackage

// File: rtl/rf_access_decode.sv
module rf_access_decode
    import rf_alias_pkg::*;
#(
    parameter int NUM_DATA = 4,
    parameter int NUM_PTR  = 4,
    localparam int NUM_REGS = NUM_DATA + NUM_PTR,
    localparam int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] reg_idx,
    output lane_e            lane,
    output logic             bad
);

    localparam logic [SEL_W-1:0] DATA_LIMIT = SEL_W'(NUM_DATA);

    always_comb begin
        reg_idx = sel;
        lane    = LANE_WORD;
        bad     = 1'b0;
        unique case (acc_mode_e'(mode))
            ACC_WORD: begin
                reg_idx = sel;
            end
            ACC_BCODE: begin
                if (sel < DATA_LIMIT) begin
                    lane = LANE_LOW;
                end else begin
                    lane    = LANE_HIGH;
                    reg_idx = sel - DATA_LIMIT;
                end
            end
            ACC_LO: begin
                lane = LANE_LOW;
                bad  = (sel >= DATA_LIMIT);
            end
            ACC_HI: begin
                lane = LANE_HIGH;
                bad  = (sel >= DATA_LIMIT);
            end
        endcase
    end

endmodule

// File: rtl/rf_lane_storage.sv
module rf_lane_storage
    import rf_alias_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int BYTE_W  = DATA_W / 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             widx,
    input  lane_e                        wlane,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_REGS*DATA_W-1:0]   q_flat,
    output logic [NUM_REGS*DATA_W-1:0]   nxt_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q_r;
        logic [DATA_W-1:0] nxt_r;

        always_comb begin
            nxt_r = q_r;
            if (we && (widx == SEL_W'(g))) begin
                case (wlane)
                    LANE_WORD: nxt_r = wdata;
                    LANE_LOW:  nxt_r[BYTE_W-1:0] = wdata[BYTE_W-1:0];
                    LANE_HIGH: nxt_r[DATA_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                    default:   nxt_r = q_r;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= nxt_r;
        end

        assign q_flat[g*DATA_W +: DATA_W]   = q_r;
        assign nxt_flat[g*DATA_W +: DATA_W] = nxt_r;
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_alias_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int BYTE_W  = DATA_W / 2
) (
    input  logic [NUM_REGS*DATA_W-1:0] src_flat,
    input  logic [SEL_W-1:0]           idx,
    input  lane_e                      lane,
    input  logic                       bad,
    output logic [DATA_W-1:0]          rdata
);

    logic [DATA_W-1:0] word;

    always_comb begin
        word = src_flat[int'(idx)*DATA_W +: DATA_W];
        if (bad) begin
            rdata = '0;
        end else begin
            case (lane)
                LANE_WORD: rdata = word;
                LANE_LOW:  rdata = {{(DATA_W-BYTE_W){1'b0}}, word[BYTE_W-1:0]};
                LANE_HIGH: rdata = {{(DATA_W-BYTE_W){1'b0}}, word[DATA_W-1:BYTE_W]};
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile
    import rf_alias_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_DATA = 4,
    parameter int NUM_PTR  = 4,
    localparam int NUM_REGS = NUM_DATA + NUM_PTR,
    localparam int SEL_W    = $clog2(NUM_REGS),
    localparam int NUM_RD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_mode,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [1:0]        rd_a_mode,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_illegal,
    input  logic [1:0]        rd_b_mode,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_illegal
);

    logic [SEL_W-1:0]            w_idx;
    lane_e                       w_lane;
    logic                        w_bad;
    logic [NUM_REGS*DATA_W-1:0]  store_q;
    logic [NUM_REGS*DATA_W-1:0]  store_nxt;

    logic [1:0]        rp_mode [NUM_RD];
    logic [SEL_W-1:0]  rp_sel  [NUM_RD];
    logic [DATA_W-1:0] rp_data [NUM_RD];
    logic              rp_bad  [NUM_RD];

    rf_access_decode #(.NUM_DATA(NUM_DATA), .NUM_PTR(NUM_PTR)) u_wdec (
        .mode    (wr_mode),
        .sel     (wr_sel),
        .reg_idx (w_idx),
        .lane    (w_lane),
        .bad     (w_bad)
    );

    assign wr_illegal = wr_en && w_bad;

    rf_lane_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en && !w_bad),
        .widx     (w_idx),
        .wlane    (w_lane),
        .wdata    (wr_data),
        .q_flat   (store_q),
        .nxt_flat (store_nxt)
    );

    assign rp_mode[0] = rd_a_mode;
    assign rp_sel[0]  = rd_a_sel;
    assign rp_mode[1] = rd_b_mode;
    assign rp_sel[1]  = rd_b_sel;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
        logic [SEL_W-1:0] r_idx;
        lane_e            r_lane;

        rf_access_decode #(.NUM_DATA(NUM_DATA), .NUM_PTR(NUM_PTR)) u_rdec (
            .mode    (rp_mode[p]),
            .sel     (rp_sel[p]),
            .reg_idx (r_idx),
            .lane    (r_lane),
            .bad     (rp_bad[p])
        );

        rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
            .src_flat (store_nxt),
            .idx      (r_idx),
            .lane     (r_lane),
            .bad      (rp_bad[p]),
            .rdata    (rp_data[p])
        );
    end

    assign rd_a_data    = rp_data[0];
    assign rd_a_illegal = rp_bad[0];
    assign rd_b_data    = rp_data[1];
    assign rd_b_illegal = rp_bad[1];

endmodule

// File: rtl/byte_alias_regfile_chk.sv
module byte_alias_regfile_chk #(
    parameter int DATA_W   = 16,
    parameter int NUM_DATA = 4,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = $clog2(NUM_REGS),
    localparam int BYTE_W  = DATA_W / 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [1:0]                 wr_mode,
    input logic [SEL_W-1:0]           wr_sel,
    input logic [DATA_W-1:0]          wr_data,
    input logic                       wr_illegal,
    input logic [1:0]                 rd_a_mode,
    input logic [SEL_W-1:0]           rd_a_sel,
    input logic [DATA_W-1:0]          rd_a_data,
    input logic                       rd_a_illegal,
    input logic [1:0]                 rd_b_mode,
    input logic [SEL_W-1:0]           rd_b_sel,
    input logic [DATA_W-1:0]          rd_b_data,
    input logic                       rd_b_illegal,
    input logic [NUM_REGS*DATA_W-1:0] store_q
);

    function automatic logic [DATA_W-1:0] word_of(logic [NUM_REGS*DATA_W-1:0] f,
                                                  logic [SEL_W-1:0] i);
        return f[int'(i)*DATA_W +: DATA_W];
    endfunction

    function automatic logic [BYTE_W-1:0] hi_of(logic [NUM_REGS*DATA_W-1:0] f,
                                                logic [SEL_W-1:0] i);
        logic [DATA_W-1:0] w;
        w = f[int'(i)*DATA_W +: DATA_W];
        return w[DATA_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_of(logic [NUM_REGS*DATA_W-1:0] f,
                                                logic [SEL_W-1:0] i);
        logic [DATA_W-1:0] w;
        w = f[int'(i)*DATA_W +: DATA_W];
        return w[BYTE_W-1:0];
    endfunction

    localparam logic [SEL_W-1:0] LIM = SEL_W'(NUM_DATA);

    AST_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd0) |=> word_of(store_q, $past(wr_sel)) == $past(wr_data)) // R2
        else $error("AST_WORD_WRITE");

    AST_BYTE_ZERO_EXT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_mode != 2'd0) |-> rd_a_data[DATA_W-1:BYTE_W] == '0) // R3
        else $error("AST_BYTE_ZERO_EXT_A");

    AST_BYTE_ZERO_EXT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_mode != 2'd0) |-> rd_b_data[DATA_W-1:BYTE_W] == '0) // R3
        else $error("AST_BYTE_ZERO_EXT_B");

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd2 && wr_sel < LIM)
        |=> hi_of(store_q, $past(wr_sel)) == $past(hi_of(store_q, wr_sel))) // R5
        else $error("AST_LO_KEEPS_HI");

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd3 && wr_sel < LIM)
        |=> lo_of(store_q, $past(wr_sel)) == $past(lo_of(store_q, wr_sel))) // R5
        else $error("AST_HI_KEEPS_LO");

    AST_PTR_LANE_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_mode[1] && rd_a_sel >= LIM) |-> (rd_a_illegal && rd_a_data == '0)) // R6
        else $error("AST_PTR_LANE_FLAG_A");

    AST_PTR_LANE_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_mode[1] && rd_b_sel >= LIM) |-> (rd_b_illegal && rd_b_data == '0)) // R6
        else $error("AST_PTR_LANE_FLAG_B");

    AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(store_q)) // R6
        else $error("AST_ILLEGAL_NO_CHANGE");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(store_q) && !$past(wr_illegal))) // R8
        else $error("AST_IDLE_HOLD");

    AST_WORD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode == 2'd0 && rd_a_mode == 2'd0 && rd_a_sel == wr_sel)
        |-> rd_a_data == wr_data) // R7
        else $error("AST_WORD_BYPASS");

endmodule

bind byte_alias_regfile byte_alias_regfile_chk #(
    .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_mode      (wr_mode),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .wr_illegal   (wr_illegal),
    .rd_a_mode    (rd_a_mode),
    .rd_a_sel     (rd_a_sel),
    .rd_a_data    (rd_a_data),
    .rd_a_illegal (rd_a_illegal),
    .rd_b_mode    (rd_b_mode),
    .rd_b_sel     (rd_b_sel),
    .rd_b_data    (rd_b_data),
    .rd_b_illegal (rd_b_illegal),
    .store_q      (store_q)
);

// File: tb/tb_byte_alias_regfile.sv
module tb_byte_alias_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_mode = '0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        wr_illegal;
    logic [1:0]  rd_a_mode = '0;
    logic [2:0]  rd_a_sel = '0;
    logic [15:0] rd_a_data;
    logic        rd_a_illegal;
    logic [1:0]  rd_b_mode = '0;
    logic [2:0]  rd_b_sel = '0;
    logic [15:0] rd_b_data;
    logic        rd_b_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] mdl [8];

    always #4 clk = ~clk;

    byte_alias_regfile dut (.*);

    task automatic ck(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void dec(input logic [1:0] m, input logic [2:0] s,
                                output int idx, output int lane, output bit bad);
        idx = int'(s); lane = 0; bad = 1'b0;
        case (m)
            2'd1: begin
                if (s < 3'd4) lane = 1;
                else begin lane = 2; idx = int'(s) - 4; end
            end
            2'd2: begin lane = 1; bad = (s >= 3'd4); end
            2'd3: begin lane = 2; bad = (s >= 3'd4); end
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] m [8],
                                           input logic [1:0] md, input logic [2:0] s);
        int i; int l; bit b;
        dec(md, s, i, l, b);
        if (b) return 16'h0000;
        if (l == 0) return m[i];
        if (l == 1) return {8'h00, m[i][7:0]};
        return {8'h00, m[i][15:8]};
    endfunction

    task automatic cyc(input string req, input bit we, input logic [1:0] wm,
                       input logic [2:0] ws, input logic [15:0] wd,
                       input logic [1:0] am, input logic [2:0] as_,
                       input logic [1:0] bm, input logic [2:0] bs);
        logic [15:0] nm [8];
        int i; int l; bit b;
        @(negedge clk);
        wr_en = we; wr_mode = wm; wr_sel = ws; wr_data = wd;
        rd_a_mode = am; rd_a_sel = as_; rd_b_mode = bm; rd_b_sel = bs;
        for (int k = 0; k < 8; k++) nm[k] = mdl[k];
        dec(wm, ws, i, l, b);
        if (we && !b) begin
            if (l == 0) nm[i] = wd;
            else if (l == 1) nm[i][7:0] = wd[7:0];
            else nm[i][15:8] = wd[7:0];
        end
        #2;
        ck(rd_a_data == exp_rd(nm, am, as_), req, "port A data", rd_a_data, exp_rd(nm, am, as_));
        ck(rd_b_data == exp_rd(nm, bm, bs), req, "port B data", rd_b_data, exp_rd(nm, bm, bs));
        dec(am, as_, i, l, b);
        ck(rd_a_illegal == b, req, "port A illegal", 16'(rd_a_illegal), 16'(b));
        dec(bm, bs, i, l, b);
        ck(rd_b_illegal == b, req, "port B illegal", 16'(rd_b_illegal), 16'(b));
        dec(wm, ws, i, l, b);
        ck(wr_illegal == (we && b), req, "wr_illegal", 16'(wr_illegal), 16'(we && b));
        for (int k = 0; k < 8; k++) mdl[k] = nm[k];
    endtask

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset contents through both ports in word mode
        for (int i = 0; i < 4; i++)
            cyc("R1", 1'b0, 2'd0, 3'd0, 16'h0, 2'd0, 3'(i), 2'd0, 3'(i + 4));

        // R2 and R7: word writes read back in the same cycle on port A; byte code on B
        for (int i = 0; i < 8; i++)
            cyc("R2/R7", 1'b1, 2'd0, 3'(i), 16'h1000 * 16'(i + 1) + 16'h0123 * 16'(i + 2),
                2'd0, 3'(i), 2'd1, 3'(i));

        // R3, R4, R6, R9: full read sweep, ports on different requests
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 8; s++)
                cyc("R3/R4/R6/R9", 1'b0, 2'd0, 3'd0, 16'h0,
                    2'(m), 3'(s), 2'(3 - m), 3'(7 - s));

        // R5, R6, R7: every byte write form; A sees whole word, B sees written lane
        for (int m = 1; m < 4; m++)
            for (int s = 0; s < 8; s++)
                cyc("R5/R6/R7", 1'b1, 2'(m), 3'(s),
                    {8'hEE, 8'(m * 37 + s * 11)},
                    2'd0, (m == 1) ? 3'(s % 4) : 3'(s), 2'(m), 3'(s));

        // R5: byte writes followed by word reads next cycle
        cyc("R5", 1'b1, 2'd2, 3'd1, 16'hFF5A, 2'd0, 3'd1, 2'd3, 3'd1);
        cyc("R5", 1'b1, 2'd3, 3'd2, 16'hFFA5, 2'd0, 3'd2, 2'd1, 3'd2);
        cyc("R5", 1'b0, 2'd0, 3'd0, 16'h0, 2'd0, 3'd1, 2'd0, 3'd2);

        // R8: disabled write with data present changes nothing
        cyc("R8", 1'b0, 2'd0, 3'd0, 16'hFFFF, 2'd0, 3'd0, 2'd0, 3'd5);
        cyc("R8", 1'b0, 2'd2, 3'd6, 16'h00FF, 2'd0, 3'd0, 2'd0, 3'd6);

        // R6: illegal write of a pointer lane, then word read next cycle
        cyc("R6", 1'b1, 2'd3, 3'd7, 16'h00C3, 2'd0, 3'd7, 2'd3, 3'd7);
        cyc("R6", 1'b0, 2'd0, 3'd0, 16'h0, 2'd0, 3'd7, 2'd2, 3'd4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule